// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial-peripheral master driven through a small word-wide register file. Software programs the clock polarity, clock phase and word length in a configuration register, then selects one of eight peripherals with an encoded index and a separate enable bit in a control register. Select lines are active low. A write to the transmit-data register launches one word, 8 or 16 bits, most significant bit first. The word returning on the input line is captured at the same time.

When the word is complete, a cause flag goes nonzero. Software polls this flag, reads the received word and writes zero to the flag before the next word. The serial clock is not generated inside the block: an external divider supplies a single-cycle strobe. Each strobe moves the serial clock by one half-period.

Top module: `spi_regmap_master`

## Requirements
- R1: After reset all eight select outputs are high, the serial clock output is low, and the control and cause registers read zero.
- R2: The register at byte offset 0x00 keeps the select index in bits 4:2 and the select enable in bit 0. The register at 0x04 keeps word length in bit 5, clock polarity in bit 11 and clock phase in bit 12. All other bits of both registers read back as zero.
- R3: While the select enable is set, exactly one select output is low: the one whose number equals the index. It goes low one clock after the register write. A new index moves the low line immediately. With the enable clear, every select output is high.
- R4: While no word is in flight, the serial clock rests at the configured polarity. A word of N bits toggles it exactly 2N times and leaves it at that polarity.
- R5: Bits leave on the output line most significant bit first. Both sides sample on the first clock edge of each bit when phase is 0, and on the second edge when phase is 1.
- R6: Word length bit 5 set selects 16-bit words and clear selects 8-bit words; an 8-bit word sends the low byte of the transmit write. The received word reads at offset 0x0C in the low bits, and the upper bits read zero.
- R7: The cause register at 0x10 reads 0 while a word is in flight and 1 once it has completed. Writing zero clears it. Writing a nonzero value leaves it unchanged.
- R8: A write to the transmit register at 0x08 while a word is in flight is ignored. The word in flight and its length are unaffected.
- R9: Word length, polarity and phase are taken when a word starts. Changing the configuration during the word does not alter it. The new polarity becomes the resting level once the word ends.
- R10: The serial clock changes only on a cycle where the divider strobe is high; with the strobe held low a word in flight stands still.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe for the register at reg_addr |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, registered one cycle |
| sclk_tick | input | 1 | Half-period strobe from the clock divider |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low select lines |

## Verification
The hardest situations to reach are register writes that arrive while a word is in flight: a second transmit write, and a configuration change that must not reach the word already running. The bench starts a word and then, a few strobes later, issues the write under test. It checks that the edge count, the bit pattern seen on the output line and the received word all still match the first request. A third case stops the divider strobe in mid-word to show that the serial clock freezes. The input line is wired to the inverse of the output line, so the received word is known in advance for every mode.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_TX    = 'h08;
  localparam int OFS_RX    = 'h0C;
  localparam int OFS_CAUSE = 'h10;
  // field positions
  localparam int CTRL_SEL_EN = 0;
  localparam int CTRL_IDX_LO = 2;
  localparam int CFG_W16     = 5;
  localparam int CFG_CPOL    = 11;
  localparam int CFG_CPHA    = 12;

  typedef struct packed {
    logic w16;
    logic cpol;
    logic cpha;
  } xfer_mode_t;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 3,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              sel_en,
  output logic [IDX_W-1:0]  sel_idx,
  output xfer_mode_t        mode,
  output logic              start,
  output logic [WORD_W-1:0] tx_word
);
  logic hit_ctrl, hit_cfg, hit_tx, hit_cause;
  logic cause_q;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl  = wr && (addr == ADDR_W'(OFS_CTRL));
  assign hit_cfg   = wr && (addr == ADDR_W'(OFS_CFG));
  assign hit_tx    = wr && (addr == ADDR_W'(OFS_TX));
  assign hit_cause = wr && (addr == ADDR_W'(OFS_CAUSE));

  assign start   = hit_tx && !busy;
  assign tx_word = wdata[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_en  <= 1'b0;
      sel_idx <= '0;
      mode    <= '0;
      cause_q <= 1'b0;
    end else begin
      if (hit_ctrl) begin
        sel_en  <= wdata[CTRL_SEL_EN];
        sel_idx <= wdata[CTRL_IDX_LO +: IDX_W];
      end
      if (hit_cfg) begin
        mode.w16  <= wdata[CFG_W16];
        mode.cpol <= wdata[CFG_CPOL];
        mode.cpha <= wdata[CFG_CPHA];
      end
      if (done)
        cause_q <= 1'b1;
      else if (hit_cause && (wdata == '0))
        cause_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_CTRL): begin
        rd_mux[CTRL_SEL_EN] = sel_en;
        rd_mux[CTRL_IDX_LO +: IDX_W] = sel_idx;
      end
      ADDR_W'(OFS_CFG): begin
        rd_mux[CFG_W16]  = mode.w16;
        rd_mux[CFG_CPOL] = mode.cpol;
        rd_mux[CFG_CPHA] = mode.cpha;
      end
      ADDR_W'(OFS_RX):    rd_mux[WORD_W-1:0] = rx_word;
      ADDR_W'(OFS_CAUSE): rd_mux[0] = cause_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter
  import spi_rm_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  xfer_mode_t        mode,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CNT_W   = $clog2(2*WORD_W);
  localparam int LAST_L  = 2*WORD_W - 1;
  localparam int LAST_S  = 2*SHORT_W - 1;

  xfer_mode_t        lat;
  logic [WORD_W-1:0] tx_sr, rx_sr;
  logic [CNT_W-1:0]  edge_cnt;
  logic              smp, shf, last;

  assign smp  = (edge_cnt[0] == lat.cpha);
  assign shf  = !smp && !(lat.cpha && edge_cnt == '0);
  assign last = lat.w16 ? (edge_cnt == CNT_W'(LAST_L)) : (edge_cnt == CNT_W'(LAST_S));
  assign mosi = tx_sr[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sclk     <= 1'b0;
      lat      <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      edge_cnt <= '0;
      rx_word  <= '0;
    end else begin
      done <= 1'b0;
      if (done) rx_word <= rx_sr;
      if (!busy) begin
        sclk <= mode.cpol;
        if (start) begin
          busy     <= 1'b1;
          lat      <= mode;
          rx_sr    <= '0;
          edge_cnt <= '0;
          tx_sr    <= mode.w16 ? tx_word
                               : {tx_word[SHORT_W-1:0], {(WORD_W-SHORT_W){1'b0}}};
        end
      end else if (tick) begin
        sclk     <= ~sclk;
        edge_cnt <= edge_cnt + 1'b1;
        if (smp) rx_sr <= {rx_sr[WORD_W-2:0], miso};
        if (shf) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rm_select.sv
module spi_rm_select #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_en,
  input  logic [IDX_W-1:0]  sel_idx,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) cs_n[i] <= 1'b1;
      else     cs_n[i] <= !(sel_en && (sel_idx == IDX_W'(i)));
    end
  end
endmodule

// File: rtl/spi_regmap_master.sv
module spi_regmap_master
  import spi_rm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int NUM_CS  = 8,
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_tick,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic              busy, xfer_done, start, sel_en;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] tx_word, rx_word;
  xfer_mode_t        mode;

  spi_rm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done(xfer_done), .rx_word(rx_word),
    .sel_en(sel_en), .sel_idx(sel_idx), .mode(mode), .start(start), .tx_word(tx_word)
  );

  spi_rm_shifter #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_shift (
    .clk(clk), .rst(rst), .tick(sclk_tick), .start(start), .mode(mode),
    .tx_word(tx_word), .miso(spi_miso), .busy(busy), .done(xfer_done),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(rx_word)
  );

  spi_rm_select #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .sel_en(sel_en), .sel_idx(sel_idx), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              busy,
  input logic              done,
  input logic              sel_en,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n
);
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R3
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_en) |-> (&cs_n));
  // R10
  sclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(sclk));
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(mosi));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind spi_regmap_master spi_rm_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .tick(sclk_tick), .busy(busy), .done(xfer_done),
  .sel_en(sel_en), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
);

// File: tb/spi_regmap_master_tb.sv
module spi_regmap_master_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk_tick = 0;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [7:0]  spi_cs_n;

  int errors = 0, checks = 0;
  int edges = 0;
  logic [15:0] cap = '0;
  logic prev_sclk = 0;
  logic cur_cpol = 0, cur_cpha = 0;
  logic tick_en = 1;
  int tick_div = 0;

  always #5 clk = ~clk;

  assign spi_miso = ~spi_mosi;

  spi_regmap_master u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sclk_tick(sclk_tick), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // divider strobe: one cycle in three
  always @(negedge clk) begin
    tick_div = (tick_div == 2) ? 0 : tick_div + 1;
    sclk_tick = tick_en && (tick_div == 0);
  end

  // serial monitor: count clock edges, record output bit on each sample edge
  always @(negedge clk) begin
    if (!rst && spi_sclk !== prev_sclk) begin
      edges = edges + 1;
      if ((prev_sclk == cur_cpol) ^ cur_cpha) cap = {cap[14:0], spi_mosi};
    end
    prev_sclk = spi_sclk;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic mon_clear(input logic pol, input logic pha);
    repeat (2) @(negedge clk);
    cur_cpol = pol; cur_cpha = pha; edges = 0; cap = '0;
  endtask

  task automatic wait_cause();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(5'h10, v);
      if (v != 0) return;
    end
    chk("R7 cause timeout", 32'h0, 32'h1);
  endtask

  function automatic logic [31:0] cfg_word(input logic w16, input logic pol, input logic pha);
    return (32'(w16) << 5) | (32'(pol) << 11) | (32'(pha) << 12);
  endfunction

  // {w16, cpol, cpha, tx}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 16'h7EA5}, {1'b0, 1'b1, 1'b0, 16'hFF3C},
    {1'b0, 1'b0, 1'b1, 16'h0081}, {1'b0, 1'b1, 1'b1, 16'h12F0},
    {1'b1, 1'b0, 1'b0, 16'hA55A}, {1'b1, 1'b1, 1'b1, 16'h1234},
    {1'b1, 1'b0, 1'b1, 16'h8001}, {1'b1, 1'b1, 1'b0, 16'hC3E1}
  };

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", {24'h0, spi_cs_n}, 32'hFF);
    chk("R1 sclk", {31'h0, spi_sclk}, 32'h0);
    rd(5'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(5'h10, v); chk("R1 cause", v, 32'h0);

    // R2 field readback
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R2 cfg readback", v, 32'h0000_1820);
    wr(5'h04, 32'h0);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R2 ctrl readback", v, 32'h0000_001D);
    chk("R3 index 7 selected", {24'h0, spi_cs_n}, 32'h7F);

    // R3 select handling
    wr(5'h00, 32'h09); @(negedge clk);
    chk("R3 index 2", {24'h0, spi_cs_n}, 32'hFB);
    wr(5'h00, 32'h15); @(negedge clk);
    chk("R3 switch to 5", {24'h0, spi_cs_n}, 32'hDF);
    wr(5'h00, 32'h14); @(negedge clk);
    chk("R3 enable clear", {24'h0, spi_cs_n}, 32'hFF);

    // R4 R5 R6 vector walk
    foreach (VEC[k]) begin
      logic w16, pol, pha;
      logic [15:0] tx, mask;
      int nb;
      {w16, pol, pha, tx} = VEC[k];
      nb = w16 ? 16 : 8;
      mask = w16 ? 16'hFFFF : 16'h00FF;
      wr(5'h04, cfg_word(w16, pol, pha));
      mon_clear(pol, pha);
      chk("R4 idle level", {31'h0, spi_sclk}, {31'h0, pol});
      wr(5'h08, {16'hABCD, tx});
      wait_cause();
      chk("R4 edge count", edges, 2 * nb);
      chk("R5 msb-first output", {16'h0, cap & mask}, {16'h0, tx & mask});
      rd(5'h0C, v); chk("R6 received word", v, {16'h0, ~tx & mask});
      chk("R4 rest level", {31'h0, spi_sclk}, {31'h0, pol});
      wr(5'h10, 32'h0);
    end

    // R7 cause behaviour
    wr(5'h04, cfg_word(0, 0, 0));
    mon_clear(0, 0);
    wr(5'h08, 32'h3C);
    rd(5'h10, v); chk("R7 cause during word", v, 32'h0);
    wait_cause();
    rd(5'h10, v); chk("R7 cause after word", v, 32'h1);
    wr(5'h10, 32'h5);
    rd(5'h10, v); chk("R7 nonzero write keeps", v, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, v); chk("R7 zero write clears", v, 32'h0);

    // R8 transmit write while in flight
    mon_clear(0, 0);
    wr(5'h08, 32'h5A);
    repeat (6) @(negedge clk);
    wr(5'h08, 32'hFF);
    wait_cause();
    chk("R8 edges unchanged", edges, 16);
    chk("R8 output word", {16'h0, cap}, 32'h5A);
    rd(5'h0C, v); chk("R8 received word", v, 32'hA5);
    wr(5'h10, 32'h0);

    // R9 configuration change mid-word: the word keeps 8 bits, mode 0;
    // afterwards the clock moves once to the new resting level
    mon_clear(0, 0);
    wr(5'h08, 32'h96);
    repeat (6) @(negedge clk);
    wr(5'h04, cfg_word(1, 1, 1));
    wait_cause();
    chk("R9 edges incl. rest move", edges, 17);
    chk("R9 output word", {16'h0, cap[8:1]}, 32'h96);
    rd(5'h0C, v); chk("R9 received word", v, 32'h69);
    chk("R9 new rest level", {31'h0, spi_sclk}, 32'h1);
    wr(5'h10, 32'h0);

    // R10 strobe held low freezes the word
    wr(5'h04, cfg_word(0, 0, 0));
    mon_clear(0, 0);
    wr(5'h08, 32'hC3);
    repeat (9) @(negedge clk);
    tick_en = 0;
    @(negedge clk);
    begin
      int e0;
      e0 = edges;
      repeat (30) @(negedge clk);
      chk("R10 no edges without strobe", edges, e0);
    end
    rd(5'h10, v); chk("R10 cause still clear", v, 32'h0);
    tick_en = 1;
    wait_cause();
    chk("R10 edges after resume", edges, 16);
    rd(5'h0C, v); chk("R10 received word", v, 32'h3C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule